// File: doc/BRIEF.md
# Decoded Johnson Decade Counter

This block divides a slow count signal by ten. Its state is a five-stage twisted-ring shift register, so it steps through ten states. Each state is decoded into one of ten one-hot outputs. A carry output is high during the first half of each ten-count cycle. It rises once per cycle, just after the last decoded output falls, so a following stage can count the cycles of this one.

The count clock and the count inhibit are asynchronous to the chip. Both are sampled on a fast system clock through two-flop synchronizers. The block forms an effective count signal, which is high when the clock is high and the inhibit is low. One step is taken on each rising edge of that signal. This means a falling inhibit while the clock is high also advances the count. A master-reset input returns the count to zero and takes effect on the next system clock edge. An illegal ring pattern repairs itself within a few steps.

Top module: `decade_johnson_counter`

## Requirements
- R1: While `rstN` is low, the count is zero: `decOut` equals 10'b0000000001 (bit k is decoded output k) and `termCount` is 1.
- R2: Outside reset, exactly one bit of `decOut` is high, and that bit is the current count in the range 0 to 9.
- R3: A rising `cntClk` while `cntInh` is low advances the count by one. The new value appears after the third system clock edge that follows the input change, and not before it.
- R4: A falling `cntInh` while `cntClk` is high advances the count by one.
- R5: These inputs leave the count unchanged: clock edges while `cntInh` is high, a falling `cntClk`, a rising `cntInh`, and a falling `cntInh` while `cntClk` is low.
- R6: While `mstReset` is high, the count is forced to zero from the next system clock edge on, and count edges are ignored.
- R7: `termCount` is 1 for counts 0 to 4 and 0 for counts 5 to 9. It rises exactly once per ten steps, on the step from 9 to 0.
- R8: The count wraps from 9 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock used to sample all inputs |
| rstN | input | 1 | Active-low asynchronous system reset |
| cntClk | input | 1 | Asynchronous count clock |
| cntInh | input | 1 | Asynchronous active-high count inhibit |
| mstReset | input | 1 | Active-high master reset, applied on the next sysClk edge |
| decOut | output | 10 | One-hot decoded count (2 x NUM_STAGES) |
| termCount | output | 1 | Carry, high for counts 0 to 4 |

## Verification
The bench uses the default values NUM_STAGES=5 and SYNC_STAGES=2. With these values, a full ten-state cycle and the 9-to-0 wrap can be reached in a few hundred system clocks. The three-edge input latency can also be measured exactly. At the same time, the bench toggles `cntClk` and `cntInh` in every order that matters: clock edges under inhibit, inhibit edges with the clock high, and inhibit edges with the clock low. It also holds master reset over live clock pulses, and checks the carry edge count over twenty-five steps.

// File: rtl/jc_pkg.sv
package jc_pkg;
  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic step;   // advance the ring by one position
    logic clear;  // force the ring to all zeros
  } jcStrobe_t;
endpackage

// File: rtl/jc_ctrl.sv
module jc_ctrl
  import jc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      sysClk,
  input  logic      rstN,
  input  logic      cntClk,
  input  logic      cntInh,
  input  logic      mstReset,
  output jcStrobe_t strobe
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clkSync;
  logic [TOP:0] inhSync;
  logic         effNow;
  logic         effPrev;

  // Synchronizer chains: new samples enter at bit 0 and move up one bit per clock
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      inhSync <= '0;
      effPrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[TOP-1:0], cntClk};
      inhSync <= {inhSync[TOP-1:0], cntInh};
      effPrev <= effNow;
    end
  end

  // The effective count signal is the clock gated by the inverted inhibit
  assign effNow = clkSync[TOP] & ~inhSync[TOP];

  always_comb begin
    strobe.step  = effNow & ~effPrev;
    strobe.clear = mstReset;
  end

  AST_STEP_PULSE: assert property (@(posedge sysClk) disable iff (!rstN)
    strobe.step |=> !strobe.step); // R3
endmodule

// File: rtl/jc_datapath.sv
module jc_datapath
  import jc_pkg::*;
#(
  parameter int NUM_STAGES = 5
) (
  input  logic                      sysClk,
  input  logic                      rstN,
  input  jcStrobe_t                 strobe,
  output logic [2*NUM_STAGES-1:0]   decOut,
  output logic                      tc
);
  localparam int NUM_OUTS = 2 * NUM_STAGES;
  localparam int MSB      = NUM_STAGES - 1;

  logic [MSB:0]   jState;
  logic [MSB-1:0] adjDiff;
  logic           isLegal;
  logic           feedIn;

  // A legal twisted-ring pattern has at most one change between neighbouring stages
  assign adjDiff = jState[MSB:1] ^ jState[MSB-1:0];
  assign isLegal = ($countones(adjDiff) <= 1);

  // Correction term: an illegal pattern shifts in zeros until it becomes legal
  assign feedIn  = isLegal ? ~jState[MSB] : 1'b0;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      jState <= '0;
    end else if (strobe.clear) begin
      jState <= '0;
    end else if (strobe.step) begin
      jState <= {jState[MSB-1:0], feedIn};
    end
  end

  // Each output is decoded from two neighbouring stages
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_fill
    if (k == 0) begin : g_first
      assign decOut[0] = ~jState[MSB] & ~jState[0];
    end else begin : g_rest
      assign decOut[k] = jState[k-1] & ~jState[k];
    end
  end

  for (genvar j = 0; j < NUM_STAGES; j++) begin : g_drain
    if (j == 0) begin : g_first
      assign decOut[NUM_STAGES] = jState[MSB] & jState[0];
    end else begin : g_rest
      assign decOut[NUM_STAGES+j] = ~jState[j-1] & jState[j];
    end
  end

  // Carry is high while the ring is still filling with ones
  assign tc = ~jState[MSB];

  AST_CLEAR_ZERO: assert property (@(posedge sysClk) disable iff (!rstN)
    strobe.clear |=> (decOut[0] && tc)); // R6
  AST_HOLD_IDLE: assert property (@(posedge sysClk) disable iff (!rstN)
    (!strobe.step && !strobe.clear) |=> $stable(decOut)); // R5
  AST_ONE_HOT: assert property (@(posedge sysClk) disable iff (!rstN)
    isLegal |-> $onehot(decOut)); // R2
  AST_TC_AFTER_LAST: assert property (@(posedge sysClk) disable iff (!rstN)
    ($rose(tc) && !$past(strobe.clear)) |-> $past(decOut[NUM_OUTS-1])); // R7
endmodule

// File: rtl/decade_johnson_counter.sv
module decade_johnson_counter
  import jc_pkg::*;
#(
  parameter int NUM_STAGES  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    sysClk,
  input  logic                    rstN,
  input  logic                    cntClk,
  input  logic                    cntInh,
  input  logic                    mstReset,
  output logic [2*NUM_STAGES-1:0] decOut,
  output logic                    termCount
);
  jcStrobe_t strobe;

  jc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .cntClk   (cntClk),
    .cntInh   (cntInh),
    .mstReset (mstReset),
    .strobe   (strobe)
  );

  jc_datapath #(.NUM_STAGES(NUM_STAGES)) u_dp (
    .sysClk (sysClk),
    .rstN   (rstN),
    .strobe (strobe),
    .decOut (decOut),
    .tc     (termCount)
  );
endmodule

// File: tb/sim_decade_johnson_counter.sv
module sim_decade_johnson_counter;
  logic       sysClk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntClk = 1'b0;
  logic       cntInh = 1'b0;
  logic       mstReset = 1'b0;
  logic [9:0] decOut;
  logic       termCount;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  int refCount = 0;
  bit hist[$] = '{0, 0, 0, 0};

  always #4 sysClk = ~sysClk;

  decade_johnson_counter u0 (
    .sysClk(sysClk), .rstN(rstN), .cntClk(cntClk), .cntInh(cntInh),
    .mstReset(mstReset), .decOut(decOut), .termCount(termCount)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitN(int n);
    for (int i = 0; i < n; i++) @(negedge sysClk);
  endtask

  task automatic pulse();
    cntClk = 1'b1; waitN(4);
    cntClk = 1'b0; waitN(4);
  endtask

  function automatic logic [31:0] hot(int c);
    return 32'(1) << c;
  endfunction

  // Reference model: a step happens three edges after the effective signal rises
  always @(posedge sysClk) begin
    cycles++;
    if (!rstN) begin
      refCount = 0;
      hist = '{0, 0, 0, 0};
    end else begin
      hist.push_front(cntClk & ~cntInh);
      void'(hist.pop_back());
      if (mstReset) refCount = 0;
      else if (hist[2] && !hist[3]) refCount = (refCount + 1) % 10;
    end
  end

  // Compare against the model on every clock, away from the active edge
  always @(negedge sysClk) begin
    if (rstN) begin
      check("R2", "decOut vs model", 32'(decOut), hot(refCount));
      check("R7", "termCount vs model", 32'(termCount), 32'(refCount < 5));
    end
  end

  // Watchdog
  always @(posedge sysClk) begin
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int rises;
    logic prevTc;
    waitN(3);
    check("R1", "reset decOut", 32'(decOut), 32'h1);
    check("R1", "reset termCount", 32'(termCount), 32'h1);
    rstN = 1'b1;
    waitN(2);

    // R3: latency of exactly three edges
    cntClk = 1'b1;
    waitN(2);
    check("R3", "no advance before third edge", 32'(decOut), hot(0));
    waitN(1);
    check("R3", "advance on third edge", 32'(decOut), hot(1));
    waitN(3);
    cntClk = 1'b0; waitN(4);
    check("R5", "falling clock ignored", 32'(decOut), hot(1));

    // R5: clock edges under inhibit
    cntInh = 1'b1; waitN(4);
    pulse(); pulse();
    check("R5", "clock under inhibit ignored", 32'(decOut), hot(1));
    cntClk = 1'b1; waitN(4);
    check("R5", "rising clock under inhibit", 32'(decOut), hot(1));
    // R4: falling inhibit with clock high
    cntInh = 1'b0; waitN(4);
    check("R4", "falling inhibit advances", 32'(decOut), hot(2));
    cntInh = 1'b1; waitN(4);
    check("R5", "rising inhibit ignored", 32'(decOut), hot(2));
    cntClk = 1'b0; waitN(4);
    cntInh = 1'b0; waitN(4);
    check("R5", "falling inhibit with clock low", 32'(decOut), hot(2));

    pulse(); pulse(); pulse();
    check("R7", "count 5 decOut", 32'(decOut), hot(5));
    check("R7", "count 5 termCount low", 32'(termCount), 32'h0);

    // R6: master reset overrides count edges
    mstReset = 1'b1; waitN(1);
    check("R6", "master reset clears", 32'(decOut), hot(0));
    pulse(); pulse();
    check("R6", "pulses under master reset", 32'(decOut), hot(0));
    mstReset = 1'b0; waitN(4);
    check("R6", "after master reset release", 32'(decOut), hot(0));

    // R7 / R8: long run with wrap
    rises = 0;
    for (int s = 1; s <= 25; s++) begin
      prevTc = termCount;
      pulse();
      if (!prevTc && termCount) rises++;
      check("R7", "termCount per step", 32'(termCount), 32'((s % 10) < 5));
      if (s % 10 == 0) check("R8", "wrap to zero", 32'(decOut), hot(0));
    end
    check("R7", "carry rises in 25 steps", 32'(rises), 32'd2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule